// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

This block is the purely combinational arithmetic core of a simple integer datapath. Four sub-units work side by side on the same operands. An adder/subtractor, a bitwise logic unit, a barrel shifter and a signed set-less-than path each produce a result. A two-bit unit selector then chooses which of the four results leaves the block. Alongside the result, the block reports two flags. A zero flag lets branch-equality logic test a subtraction. A signed overflow flag reports overflow from the adder.

The set-less-than path has no comparator of its own. It forces the shared adder into subtraction and takes the sign of the difference exclusive-ORed with the signed overflow. This gives a correct signed ordering even when the difference wraps.

Top module: `mf_alu`

## Requirements
- R1: `unit_sel` picks the output: 2'b00 logic unit, 2'b01 adder/subtractor, 2'b10 set-less-than, 2'b11 shifter.
- R2: With `unit_sel`=01, `sub_fn[0]`=0 gives `opa + opb` and `sub_fn[0]`=1 gives `opa - opb`, both modulo 2^32. `sub_fn[1]` has no effect.
- R3: `ovf` is 1 exactly when the selected unit is the adder/subtractor and the signed two's-complement add or subtract overflows. For every other `unit_sel` value, `ovf` is 0.
- R4: With `unit_sel`=00, `sub_fn` selects the bitwise operation: 00 AND, 01 OR, 10 XOR, 11 NOR of `opa` and `opb`.
- R5: With `unit_sel`=11, `shift_op` selects the operation on `opb`: 00 passes `opb` unchanged, 01 shifts left logically, 10 shifts right logically, 11 shifts right arithmetically (sign fill).
- R6: The shift distance is `shamt`, a 5-bit count covering 0 to 31. A count of 0 leaves `opb` unchanged for every shift operation.
- R7: With `unit_sel`=10, bit 0 of the result is 1 when `opa` < `opb` as signed 32-bit values, and the upper 31 bits are 0. This holds for any `sub_fn` value and for operand pairs whose difference overflows.
- R8: `zero` is 1 exactly when the selected 32-bit result is all zeros, whichever unit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; also the value that is shifted |
| shamt | input | 5 | Shift distance |
| shift_op | input | 2 | Shift operation code |
| sub_fn | input | 2 | Logic operation code; bit 0 selects subtract in the arithmetic unit |
| unit_sel | input | 2 | Result source selector |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the arithmetic unit |

## Verification
The bench aims at signed set-less-than pairs whose difference overflows. A design that used only the sign bit of the difference would invert its answer for these pairs. It also drives arithmetic right shifts of negative values by 31, which expose a design that zero-fills. It drives shift counts of 0 and 31, which catch an off-by-one stage in the barrel. Overflow is driven hard while a non-arithmetic unit is selected, to catch a flag that leaks from the adder. Subtractions of equal operands must raise `zero`, and the NOR code must invert OR. Random vectors over all selector codes then cover mux decode mistakes.

// File: rtl/mf_alu_pkg.sv
// Package: shared encodings for the multifunction ALU.
// Assumes: the unit, logic and shift codes below are fixed by the datapath decoder.
package mf_alu_pkg;

    typedef enum logic [1:0] {
        UNIT_LOGIC = 2'b00,
        UNIT_ARITH = 2'b01,
        UNIT_SLT   = 2'b10,
        UNIT_SHIFT = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_XOR = 2'b10,
        LOG_NOR = 2'b11
    } logic_e;

    typedef enum logic [1:0] {
        SHF_NONE = 2'b00,
        SHF_SLL  = 2'b01,
        SHF_SRL  = 2'b10,
        SHF_SRA  = 2'b11
    } shift_e;

endpackage

// File: rtl/mf_alu_addsub.sv
// Module: single adder with carry-in serving add and subtract.
// Does: computes a + b or a + ~b + 1, and flags signed overflow.
// Assumes: sub is already resolved by the caller (set-less-than forces it).
module mf_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf_raw
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // Conditionally invert b and add with carry-in equal to sub.
    always_comb begin
        b_eff   = b ^ {WIDTH{sub}};
        sum     = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
        ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/mf_alu_logic.sv
// Module: bitwise logic unit.
// Does: AND, OR, XOR or NOR of the operands, chosen by a 2-bit code.
// Assumes: codes follow mf_alu_pkg::logic_e.
module mf_alu_logic
    import mf_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        unique case (logic_e'(fn))
            LOG_AND: y = a & b;
            LOG_OR:  y = a | b;
            LOG_XOR: y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/mf_alu_shift.sv
// Module: logarithmic barrel shifter.
// Does: pass, logical left, logical right or arithmetic right shift of v.
// Assumes: WIDTH is a power of two. A left shift reuses the right-shift stages
//          by reversing the bit order on entry and exit.
module mf_alu_shift
    import mf_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] v,
    input  logic [SHW-1:0]   amt,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] y
);
    logic             left;
    logic             fill;
    logic [WIDTH-1:0] v_rev;
    logic [WIDTH-1:0] out_rev;
    logic [WIDTH-1:0] stage [SHW+1];

    // Decode direction and fill bit for the stages.
    always_comb begin
        left = (shift_e'(op) == SHF_SLL);
        fill = (shift_e'(op) == SHF_SRA) ? v[WIDTH-1] : 1'b0;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_rev
            assign v_rev[i]   = v[WIDTH-1-i];
            assign out_rev[i] = stage[SHW][WIDTH-1-i];
        end
    endgenerate

    assign stage[0] = left ? v_rev : v;

    genvar k;
    generate
        for (k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k]
                ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                : stage[k];
        end
    endgenerate

    // Choose the pass-through or the shifted value in final bit order.
    always_comb begin
        unique case (shift_e'(op))
            SHF_NONE: y = v;
            SHF_SLL:  y = out_rev;
            default:  y = stage[SHW];
        endcase
    end
endmodule

// File: rtl/mf_alu.sv
// Module: top of the multifunction ALU.
// Does: runs adder, logic, shifter and set-less-than in parallel and muxes one
//       result out, with zero and signed overflow flags.
// Assumes: fully combinational, so it has no clock or reset. Overflow is only
//          meaningful for the arithmetic unit and reads 0 otherwise.
module mf_alu
    import mf_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [SHW-1:0]   shamt,
    input  logic [1:0]       shift_op,
    input  logic [1:0]       sub_fn,
    input  logic [1:0]       unit_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf
);
    logic             do_sub;
    logic [WIDTH-1:0] sum;
    logic             ovf_raw;
    logic [WIDTH-1:0] log_y;
    logic [WIDTH-1:0] shf_y;
    logic [WIDTH-1:0] slt_y;

    // Set-less-than always needs a subtraction.
    always_comb begin
        do_sub = (unit_e'(unit_sel) == UNIT_SLT) || sub_fn[0];
    end

    mf_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a       (opa),
        .b       (opb),
        .sub     (do_sub),
        .sum     (sum),
        .ovf_raw (ovf_raw)
    );

    mf_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (sub_fn),
        .y  (log_y)
    );

    mf_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .v   (opb),
        .amt (shamt),
        .op  (shift_op),
        .y   (shf_y)
    );

    // Signed less-than from difference sign corrected by overflow.
    always_comb begin
        slt_y    = '0;
        slt_y[0] = sum[WIDTH-1] ^ ovf_raw;
    end

    // Result mux and flags.
    always_comb begin
        unique case (unit_e'(unit_sel))
            UNIT_LOGIC: result = log_y;
            UNIT_ARITH: result = sum;
            UNIT_SLT:   result = slt_y;
            default:    result = shf_y;
        endcase
        zero = (result == '0);
        ovf  = (unit_e'(unit_sel) == UNIT_ARITH) && ovf_raw;
    end
endmodule

// File: rtl/mf_alu_chk.sv
// Module: property checker for mf_alu, attached with bind.
// Does: cross-checks outputs against input conditions with immediate assertions.
// Assumes: combinational target, so checks evaluate whenever the ports change.
module mf_alu_chk #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [SHW-1:0]   shamt,
    input logic [1:0]       shift_op,
    input logic [1:0]       sub_fn,
    input logic [1:0]       unit_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             ovf
);
    // Port-level consistency checks.
    always_comb begin
        if (unit_sel != 2'b01)
            AST_NO_OVERFLOW: assert (!ovf);                                  // R3
        if (unit_sel == 2'b10)
            AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0);           // R7
        if (unit_sel == 2'b10 && opa == opb)
            AST_SLT_EQUAL_FALSE: assert (result == '0 && zero);              // R7
        if (unit_sel == 2'b11 && shift_op == 2'b00)
            AST_SHIFT_PASS: assert (result == opb);                          // R5
        if (unit_sel == 2'b11 && shamt == '0)
            AST_SHIFT_ZERO_COUNT: assert (result == opb);                    // R6
        if (unit_sel == 2'b01 && sub_fn[0] && opa == opb)
            AST_SUB_EQUAL_ZERO: assert (zero && !ovf);                       // R8
        if (unit_sel == 2'b00 && sub_fn == 2'b00 && (opa & opb) == '0)
            AST_AND_DISJOINT_ZERO: assert (zero);                            // R8
    end
endmodule

bind mf_alu mf_alu_chk #(.WIDTH(WIDTH)) u_mf_alu_chk (
    .opa      (opa),
    .opb      (opb),
    .shamt    (shamt),
    .shift_op (shift_op),
    .sub_fn   (sub_fn),
    .unit_sel (unit_sel),
    .result   (result),
    .zero     (zero),
    .ovf      (ovf)
);

// File: tb/test_mf_alu.sv
// Bench: scoreboard for mf_alu. A driver task applies a vector and queues the
// model's expectation; a monitor on the falling edge pops and compares.
module test_mf_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] res;
        logic        zf;
        logic        of;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  shift_op = '0;
    logic [1:0]  sub_fn = '0;
    logic [1:0]  unit_sel = '0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    bit   done  = 0;
    exp_t sb_q[$];

    mf_alu i_mf_alu (
        .opa      (opa),
        .opb      (opb),
        .shamt    (shamt),
        .shift_op (shift_op),
        .sub_fn   (sub_fn),
        .unit_sel (unit_sel),
        .result   (result),
        .zero     (zero),
        .ovf      (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model written from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] sh, input logic [1:0] so,
                                   input logic [1:0] sf, input logic [1:0] us);
        exp_t e;
        logic signed [32:0] wide;
        e.of = 1'b0;
        case (us)
            2'b00: case (sf)
                2'b00: e.res = a & b;
                2'b01: e.res = a | b;
                2'b10: e.res = a ^ b;
                default: e.res = ~(a | b);
            endcase
            2'b01: begin
                if (sf[0]) wide = $signed({a[31], a}) - $signed({b[31], b});
                else       wide = $signed({a[31], a}) + $signed({b[31], b});
                e.res = wide[31:0];
                e.of  = (wide[32] != wide[31]);
            end
            2'b10: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: case (so)
                2'b00: e.res = b;
                2'b01: e.res = b << sh;
                2'b10: e.res = b >> sh;
                default: e.res = $unsigned($signed(b) >>> sh);
            endcase
        endcase
        e.zf = (e.res == 32'd0);
        e.tag = "";
        return e;
    endfunction

    // Driver: apply one vector after the rising edge and queue its expectation.
    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [1:0] so,
                         input logic [1:0] sf, input logic [1:0] us,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        opa = a; opb = b; shamt = sh; shift_op = so; sub_fn = sf; unit_sel = us;
        e = model(a, b, sh, so, sf, us);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare settled outputs at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (result !== e.res || zero !== e.zf || ovf !== e.of) begin
                n_bad++;
                $display("FAIL %s: got res=%h zero=%b ovf=%b expected res=%h zero=%b ovf=%b",
                         e.tag, result, zero, ovf, e.res, e.zf, e.of);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected under %0d", cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1 idle state: all-zero inputs select logic AND of zeros.
        drive(32'h0, 32'h0, 5'd0, 2'b00, 2'b00, 2'b00, "R1 reset state");
        // R1 same operands through every unit.
        for (int u = 0; u < 4; u++)
            drive(32'h1234_5678, 32'h0F0F_00F3, 5'd4, 2'b01, 2'b01, 2'(u), "R1 unit select");
        // R2 add / subtract, sub_fn[1] ignored.
        drive(32'd7, 32'd5, 5'd0, 2'b00, 2'b00, 2'b01, "R2 add");
        drive(32'd7, 32'd5, 5'd0, 2'b00, 2'b01, 2'b01, "R2 sub");
        drive(32'd7, 32'd5, 5'd0, 2'b00, 2'b10, 2'b01, "R2 add fn1 ignored");
        drive(32'd5, 32'd7, 5'd0, 2'b00, 2'b11, 2'b01, "R2 sub fn1 ignored");
        drive(32'hFFFF_FFFF, 32'd1, 5'd0, 2'b00, 2'b00, 2'b01, "R2 wrap add");
        // R3 overflow cases and suppression.
        drive(32'h7FFF_FFFF, 32'd1, 5'd0, 2'b00, 2'b00, 2'b01, "R3 pos add ovf");
        drive(32'h8000_0000, 32'h8000_0000, 5'd0, 2'b00, 2'b00, 2'b01, "R3 neg add ovf");
        drive(32'h8000_0000, 32'd1, 5'd0, 2'b00, 2'b01, 2'b01, "R3 sub ovf");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 2'b00, 2'b01, 2'b01, "R3 sub ovf 2");
        drive(32'h7FFF_FFFF, 32'd1, 5'd0, 2'b00, 2'b00, 2'b00, "R3 ovf hidden logic");
        drive(32'h7FFF_FFFF, 32'd1, 5'd0, 2'b00, 2'b00, 2'b11, "R3 ovf hidden shift");
        drive(32'h8000_0000, 32'd1, 5'd0, 2'b00, 2'b01, 2'b10, "R3 ovf hidden slt");
        // R4 logic functions.
        for (int f = 0; f < 4; f++)
            drive(32'hF0F0_3C3C, 32'hFF00_5A5A, 5'd0, 2'b00, 2'(f), 2'b00, "R4 logic op");
        drive(32'h0, 32'h0, 5'd0, 2'b00, 2'b11, 2'b00, "R4 nor of zeros");
        // R5 / R6 shifts.
        for (int s = 0; s < 4; s++) begin
            drive(32'h0, 32'h8000_00F1, 5'd0,  2'(s), 2'b00, 2'b11, "R6 count zero");
            drive(32'h0, 32'h8000_00F1, 5'd31, 2'(s), 2'b00, 2'b11, "R6 count max");
            drive(32'h0, 32'h8000_00F1, 5'd1,  2'(s), 2'b00, 2'b11, "R5 shift by one");
            drive(32'h0, 32'hC3A5_1E77, 5'd13, 2'(s), 2'b00, 2'b11, "R5 shift mid");
        end
        drive(32'h0, 32'h7000_0000, 5'd31, 2'b11, 2'b00, 2'b11, "R5 sra positive");
        // R7 set-less-than, including overflowing differences and any sub_fn.
        drive(32'h8000_0000, 32'd1, 5'd0, 2'b00, 2'b00, 2'b10, "R7 min lt one");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 2'b00, 2'b10, 2'b10, "R7 max vs neg");
        drive(32'hFFFF_FFFF, 32'd0, 5'd0, 2'b00, 2'b11, 2'b10, "R7 neg lt zero");
        drive(32'd3, 32'd3, 5'd0, 2'b00, 2'b01, 2'b10, "R7 equal");
        drive(32'd2, 32'd9, 5'd0, 2'b00, 2'b00, 2'b10, "R7 small lt");
        // R8 zero flag across units.
        drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0, 2'b00, 2'b01, 2'b01, "R8 sub equal");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 5'd0, 2'b00, 2'b00, 2'b00, "R8 and disjoint");
        drive(32'h0, 32'h0000_0001, 5'd1, 2'b10, 2'b00, 2'b11, "R8 shifted out");
        drive(32'hFFFF_FFFF, 32'd1, 5'd0, 2'b00, 2'b00, 2'b01, "R8 add to zero");
        // Random sweep over every selector and code.
        for (int n = 0; n < 600; n++)
            drive($urandom, $urandom, 5'($urandom), 2'($urandom), 2'($urandom),
                  2'($urandom), "R1 random");
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule